// File: doc/BRIEF.md
# Three-Phase Gate Deadtime Guard

This block sits between the commutation logic of a three-phase bridge and the gate drivers. For each phase it takes a requested upper-switch enable and a requested lower-switch enable and produces the registered gate enables. Whenever control of a phase moves from one switch to the other, the block makes sure that both gates of that phase stay off for at least a minimum number of clock cycles. If the command itself already leaves a longer gap, the block passes it on unchanged.

A turn-off takes effect on the next clock edge. A turn-on of one side waits until the opposite side of the same phase has been off for `DT_CYCLES` cycles. One parameter sets this count for every phase and for both directions, so the deadtime is matched everywhere.

A force-off input from the protection logic drops all six gates at once. It also clears the off-time counting, so full deadtime must elapse again before any gate may turn on. If both sides of a phase are requested together, the request is treated as illegal and both gates of that phase are held off. With a 200 MHz clock, the default of 170 cycles gives 850 ns.

Top module: `gate_deadtime`

## Requirements
- R1: A synchronous active-high `rst` drives every gate output low and clears the off-time counting. After `rst` is released, no gate turns on before `DT_CYCLES` cycles have passed.
- R2: `hi_gate[p]` and `lo_gate[p]` are never high in the same cycle, for any phase p.
- R3: When the request for a side is withdrawn, that side's gate goes low on the first clock edge after the withdrawal.
- R4: A side may turn on when its opposite has already been off for at least `DT_CYCLES` cycles. In that case its gate rises on the first edge after the request, which matches the one-cycle latency of turn-off, and the commanded gap is kept unmodified.
- R5: If the opposite side has been off for fewer than `DT_CYCLES` cycles, turn-on is postponed to the first edge at which that side has been off for exactly `DT_CYCLES` cycles. The same count applies in both directions and in all phases.
- R6: If `hi_req[p]` and `lo_req[p]` are both high, both gates of phase p are low from the next edge on.
- R7: While `force_off` is high, every gate goes low on the next edge. No gate turns on until `DT_CYCLES` cycles have passed since the last cycle in which `force_off` was high.
- R8: Each phase acts only on its own request bits and its own state. A transition in one phase does not change the outputs of another phase.
- R9: If a request is withdrawn while its turn-on is still being postponed, the gate never rises for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| force_off | input | 1 | Protection shutdown of all gates, active high |
| hi_req | input | NPH | Requested upper-switch enable, one bit per phase |
| lo_req | input | NPH | Requested lower-switch enable, one bit per phase |
| hi_gate | output | NPH | Registered upper gate enable, one bit per phase |
| lo_gate | output | NPH | Registered lower gate enable, one bit per phase |

## Verification
The bench targets several corner cases, and each one catches a specific kind of fault:
- **Same-cycle handover.** One side is released and the other requested in the same cycle. A guard that is off by one lets the gate rise one cycle early or late, and a missing guard overlaps the gates.
- **Gap just over the minimum.** A gap that already exceeds the deadtime must pass with one-cycle latency. A design that always adds deadtime would lengthen it.
- **Request withdrawn while waiting.** Here the gate must never rise. A design that latches the pending turn-on would fire a stray pulse.
- **Force-off pulse.** A single-cycle pulse must also restart the counting. A design that only masks the outputs would re-enable the gates at once.
- **Reset and random traffic.** The bench checks the output state right after reset. Long random runs across independent phases are compared against a cycle model every cycle.

// File: rtl/gd_pkg.sv
package gd_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;
endpackage

// File: rtl/gd_offtimer.sv
module gd_offtimer #(
  parameter int DT_CYCLES = 170
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_clr,
  output logic ready
);
  localparam int CW = (DT_CYCLES > 2) ? $clog2(DT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold_clr) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LAST);

  assert_clear_drops_ready_R7: assert property (@(posedge clk) disable iff (rst)
    hold_clr |=> !ready);
  assert_ready_needs_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(!hold_clr));
endmodule

// File: rtl/gd_phase.sv
module gd_phase
  import gd_pkg::*;
#(
  parameter int DT_CYCLES = 170
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       force_off,
  input  gate_pair_t req,
  output gate_pair_t gate
);
  logic hi_q, lo_q;
  logic hi_off_rdy, lo_off_rdy;
  logic hi_want, lo_want;

  // Each side counts its own off time; the opposite side reads it.
  gd_offtimer #(.DT_CYCLES(DT_CYCLES)) u_hi_off (
    .clk(clk), .rst(rst), .hold_clr(force_off | hi_q), .ready(hi_off_rdy)
  );
  gd_offtimer #(.DT_CYCLES(DT_CYCLES)) u_lo_off (
    .clk(clk), .rst(rst), .hold_clr(force_off | lo_q), .ready(lo_off_rdy)
  );

  assign hi_want = req.hi & ~req.lo & ~force_off;
  assign lo_want = req.lo & ~req.hi & ~force_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_want & (hi_q | lo_off_rdy);
      lo_q <= lo_want & (lo_q | hi_off_rdy);
    end
  end

  assign gate.hi = hi_q;
  assign gate.lo = lo_q;

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));
  assert_hi_release_R3: assert property (@(posedge clk) disable iff (rst)
    !req.hi |=> !hi_q);
  assert_lo_release_R3: assert property (@(posedge clk) disable iff (rst)
    !req.lo |=> !lo_q);
  assert_hi_waits_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> $past(lo_off_rdy));
  assert_lo_waits_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> $past(hi_off_rdy));
  assert_both_req_off_R6: assert property (@(posedge clk) disable iff (rst)
    (req.hi && req.lo) |=> (!hi_q && !lo_q));
  assert_force_off_R7: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (!hi_q && !lo_q));
endmodule

// File: rtl/gate_deadtime.sv
module gate_deadtime
  import gd_pkg::*;
#(
  parameter int NPH       = 3,
  parameter int DT_CYCLES = 170
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           force_off,
  input  logic [NPH-1:0] hi_req,
  input  logic [NPH-1:0] lo_req,
  output logic [NPH-1:0] hi_gate,
  output logic [NPH-1:0] lo_gate
);
  initial begin
    if (DT_CYCLES < 2) $error("DT_CYCLES must be at least 2");
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gate_pair_t req_p, gate_p;
    assign req_p.hi = hi_req[p];
    assign req_p.lo = lo_req[p];

    gd_phase #(.DT_CYCLES(DT_CYCLES)) u_phase (
      .clk(clk), .rst(rst), .force_off(force_off), .req(req_p), .gate(gate_p)
    );

    assign hi_gate[p] = gate_p.hi;
    assign lo_gate[p] = gate_p.lo;

    assert_phase_isolated_R8: assert property (@(posedge clk) disable iff (rst)
      ($stable(hi_req[p]) && $stable(lo_req[p]) && !force_off && !$past(force_off)
       && $past(hi_gate[p]) && hi_req[p] && !lo_req[p]) |=> hi_gate[p]);
  end

  assert_all_off_after_force_R7: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (hi_gate == '0 && lo_gate == '0));
endmodule

// File: tb/tb_gate_deadtime.sv
`timescale 1ns/1ps
module tb_gate_deadtime;
  localparam int NPH = 3;
  localparam int DT  = 170;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic force_off = 1'b0;
  logic [NPH-1:0] hi_req = '0;
  logic [NPH-1:0] lo_req = '0;
  logic [NPH-1:0] hi_gate, lo_gate;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  bit mh [NPH];
  bit ml [NPH];
  int rh [NPH];
  int rl [NPH];

  gate_deadtime #(.NPH(NPH), .DT_CYCLES(DT)) dut (
    .clk(clk), .rst(rst), .force_off(force_off),
    .hi_req(hi_req), .lo_req(lo_req), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  always #2.5 clk = ~clk;

  function automatic int next_run(bit on, bit f, int run);
    if (on || f) return 0;
    return (run >= DT) ? DT : run + 1;
  endfunction

  // Cycle model written from the requirements.
  function automatic void model_step();
    for (int p = 0; p < NPH; p++) begin
      if (rst) begin
        mh[p] = 0; ml[p] = 0; rh[p] = 0; rl[p] = 0;
      end else begin
        bit wh, wl;
        int nrh, nrl;
        nrh = next_run(mh[p], force_off, rh[p]);
        nrl = next_run(ml[p], force_off, rl[p]);
        wh = hi_req[p] && !lo_req[p] && !force_off;
        wl = lo_req[p] && !hi_req[p] && !force_off;
        mh[p] = wh && (mh[p] || nrl >= DT);
        ml[p] = wl && (ml[p] || nrh >= DT);
        rh[p] = nrh;
        rl[p] = nrl;
      end
    end
  endfunction

  task automatic cycle(string tag);
    logic [NPH-1:0] eh, el;
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    for (int p = 0; p < NPH; p++) begin
      eh[p] = mh[p];
      el[p] = ml[p];
    end
    vectors++;
    if (hi_gate !== eh || lo_gate !== el) begin
      miscompares++;
      $display("FAIL %s t=%0t hi=%b lo=%b expected hi=%b lo=%b",
               tag, $time, hi_gate, lo_gate, eh, el);
    end
  endtask

  task automatic run(int n, string tag);
    repeat (n) cycle(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run(3, "R1");                         // R1: outputs low in reset
    rst = 1'b0; hi_req = '1;
    run(DT + 3, "R1");                    // R1: no turn-on before DT after reset
    hi_req = '0;
    run(3, "R3");                         // R3: release drops gate next edge
    run(DT + 5, "R4");
    lo_req = '1;
    run(5, "R4");                         // R4: long gap, one-cycle turn-on
    lo_req = '0; hi_req = '1;
    run(DT + 5, "R5");                    // R5: low-to-high handover
    hi_req = '0; lo_req = '1;
    run(DT + 5, "R5");                    // R5: high-to-low handover
    lo_req = '0; hi_req = '1;
    run(20, "R9");
    hi_req = '0; lo_req = '1;
    run(20, "R9");
    lo_req = '0;
    run(DT + 5, "R9");                    // R9: withdrawn while waiting
    hi_req = '1; lo_req = '1;
    run(DT + 5, "R6");                    // R6: both requested
    lo_req = '0;
    run(DT + 5, "R6");
    force_off = 1'b1;
    run(1, "R7");
    force_off = 1'b0;
    run(DT + 5, "R7");                    // R7: restart of counting
    hi_req = 3'b101; lo_req = 3'b010;
    run(DT + 5, "R8");
    hi_req = 3'b111; lo_req = 3'b000;
    run(DT + 5, "R8");                    // R8: only phase 1 moves
    for (int s = 0; s < 300; s++) begin
      hi_req = NPH'($urandom);
      lo_req = NPH'($urandom);
      force_off = ($urandom_range(0, 15) == 0);
      run($urandom_range(1, 2 * DT), "R2");
      force_off = 1'b0;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R2 run not finished expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule